// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers the four shared PCI interrupt request lines onto a bank of sixteen legacy interrupt-controller inputs. Each request line owns one byte-wide steering register. A steering value below sixteen names the controller input that line drives. A value of sixteen or more cuts the line off. When several lines are steered to the same controller input, that input carries the logical OR of their levels.

Software sets up the steering through a small byte-wide configuration port: an offset, write data, a write strobe and combinational read data. The block registers the routed levels, so a controller input follows the request lines with one cycle of latency. It also reports, for each request line, whether the line is steered and to which input. A separate combinational helper turns a device/function number and an INTx pin into the request line that the pin is wired to, using the usual slot rotation.

Top module: `pirq_router`

## Requirements
- R1: After reset all four steering registers read 0x80, every `route_en` bit is 0 and `pic_out` is all zero.
- R2: The steering registers for lines A, B, C and D sit at configuration offsets 0x60, 0x61, 0x62 and 0x63 in that order. Reading one of these offsets returns the stored byte. Reading any other offset returns 0x00.
- R3: A write to any offset outside 0x60 to 0x63 changes no steering register and no output.
- R4: When line p has a steering value v below 16, `pic_out[v]` equals the level of `pirq_lvl[p]` sampled at the previous rising clock edge. Inputs 0 and 15 are both reachable.
- R5: A steering value of 16 or more, including 0x10 and any value with bit 7 set, disables the line: its level reaches no `pic_out` bit, its `route_en` bit is 0 and its field in `route_irq` reads 0.
- R6: Each `pic_out` bit is the OR of the levels of every enabled line steered to it. A bit stays high while any one of those lines is still high.
- R7: After a steering write, the outputs are re-evaluated from the present request levels. The new mapping appears on `pic_out` at the second rising edge after the write strobe is sampled, and the old mapping holds until then.
- R8: For an enabled line p, `route_en[p]` is 1 and `route_irq[4p+3:4p]` holds the steering value. Both change at the rising edge that samples the write.
- R9: `dev_pirq` equals (`dev_pin` + slot + 3) mod 4, where slot is `dev_fn` shifted right by 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| pirq_lvl | input | 4 | Request line levels, bit 0 = line A |
| pic_out | output | 16 | Routed controller input levels (registered) |
| route_en | output | 4 | Per-line steering enabled flag |
| route_irq | output | 16 | Per-line steered input number, 4 bits per line |
| dev_fn | input | 8 | Device/function number for the slot helper |
| dev_pin | input | 2 | INTx pin (0 = INTA) for the slot helper |
| dev_pirq | output | 2 | Request line index the pin is wired to |

## Verification
A wrong steering byte shows up at once on the read port and on `route_en`/`route_irq`. It reaches `pic_out` one edge later, as a level on the wrong controller input or a level that goes missing. A stale or corrupted level-map bit shows as a `pic_out` bit that disagrees with the OR of the steered lines, one cycle after the request levels were applied. The directed scenarios therefore pair each steering setup with several request patterns. They check the output both one cycle and two cycles after each steering write, so that latency faults can be told apart from mapping faults.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

    localparam int CFG_W = 8;

    typedef logic [CFG_W-1:0] cfg_byte_t;

    typedef struct packed {
        logic      we;
        cfg_byte_t addr;
        cfg_byte_t data;
    } cfg_wr_t;

    localparam cfg_byte_t ROUTE_RESET = 8'h80;

    // Slot rotation for four request lines: (pin + slot - 1) mod 4.
    function automatic logic [1:0] slot_to_line(input logic [1:0] slot_lo,
                                                input logic [1:0] pin);
        return pin + slot_lo + 2'd3;
    endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_router_pkg::*;
#(
    parameter int N_PIRQ = 4,
    parameter int BASE   = 8'h60
) (
    input  logic                        clk,
    input  logic                        rst,
    input  cfg_wr_t                     wr,
    input  cfg_byte_t                   rd_addr,
    output cfg_byte_t                   rd_data,
    output logic [N_PIRQ-1:0][CFG_W-1:0] route,
    output logic                        wr_hit
);
    localparam int        LW    = (N_PIRQ > 1) ? $clog2(N_PIRQ) : 1;
    localparam cfg_byte_t BASEB = CFG_W'(BASE);
    localparam cfg_byte_t CNT   = CFG_W'(N_PIRQ);

    cfg_byte_t wr_off, rd_off;
    logic      rd_hit;

    assign wr_off = wr.addr - BASEB;
    assign rd_off = rd_addr - BASEB;
    assign wr_hit = wr.we && (wr_off < CNT);
    assign rd_hit = rd_off < CNT;

    for (genvar p = 0; p < N_PIRQ; p++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                route[p] <= ROUTE_RESET;
            else if (wr_hit && wr_off[LW-1:0] == LW'(p))
                route[p] <= wr.data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_hit)
            rd_data = route[rd_off[LW-1:0]];
    end
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
    import pirq_router_pkg::*;
#(
    parameter int N_PIRQ = 4,
    parameter int N_PIC  = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_PIRQ-1:0][CFG_W-1:0] route,
    input  logic [N_PIRQ-1:0]            lvl,
    output logic [N_PIC*N_PIRQ-1:0]      lvl_map
);
    localparam int        IW  = $clog2(N_PIC);
    localparam cfg_byte_t LIM = CFG_W'(N_PIC);

    logic [N_PIC*N_PIRQ-1:0] map_d;

    for (genvar q = 0; q < N_PIC; q++) begin : g_pic
        for (genvar p = 0; p < N_PIRQ; p++) begin : g_line
            assign map_d[q*N_PIRQ+p] = lvl[p] && (route[p] < LIM)
                                       && (route[p][IW-1:0] == IW'(q));
        end
    end

    // Whole map rebuilt every cycle from current levels and steering.
    always_ff @(posedge clk) begin
        if (rst) lvl_map <= '0;
        else     lvl_map <= map_d;
    end
endmodule

// File: rtl/pirq_pic_merge.sv
module pirq_pic_merge #(
    parameter int N_PIRQ = 4,
    parameter int N_PIC  = 16
) (
    input  logic [N_PIC*N_PIRQ-1:0] lvl_map,
    output logic [N_PIC-1:0]        pic
);
    for (genvar q = 0; q < N_PIC; q++) begin : g_or
        assign pic[q] = |lvl_map[q*N_PIRQ +: N_PIRQ];
    end
endmodule

// File: rtl/pirq_route_status.sv
module pirq_route_status
    import pirq_router_pkg::*;
#(
    parameter int N_PIRQ = 4,
    parameter int N_PIC  = 16
) (
    input  logic [N_PIRQ-1:0][CFG_W-1:0]          route,
    output logic [N_PIRQ-1:0]                     en,
    output logic [N_PIRQ*$clog2(N_PIC)-1:0]       irq
);
    localparam int        IW  = $clog2(N_PIC);
    localparam cfg_byte_t LIM = CFG_W'(N_PIC);

    for (genvar p = 0; p < N_PIRQ; p++) begin : g_stat
        assign en[p]              = route[p] < LIM;
        assign irq[p*IW +: IW]    = en[p] ? route[p][IW-1:0] : '0;
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int N_PIRQ = 4,
    parameter int N_PIC  = 16,
    parameter int BASE   = 8'h60
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  logic [7:0]                        cfg_addr,
    input  logic [7:0]                        cfg_wdata,
    output logic [7:0]                        cfg_rdata,
    input  logic [N_PIRQ-1:0]                 pirq_lvl,
    output logic [N_PIC-1:0]                  pic_out,
    output logic [N_PIRQ-1:0]                 route_en,
    output logic [N_PIRQ*$clog2(N_PIC)-1:0]   route_irq,
    input  logic [7:0]                        dev_fn,
    input  logic [1:0]                        dev_pin,
    output logic [1:0]                        dev_pirq
);
    cfg_wr_t                     wr;
    logic [N_PIRQ-1:0][CFG_W-1:0] route;
    logic [N_PIC*N_PIRQ-1:0]     lvl_map;
    logic                        wr_hit;
    logic                        unused_bits;

    assign wr = '{we: cfg_we, addr: cfg_addr, data: cfg_wdata};

    pirq_route_regs #(.N_PIRQ(N_PIRQ), .BASE(BASE)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .rd_addr(cfg_addr),
        .rd_data(cfg_rdata),
        .route  (route),
        .wr_hit (wr_hit)
    );

    pirq_level_map #(.N_PIRQ(N_PIRQ), .N_PIC(N_PIC)) u_map (
        .clk    (clk),
        .rst    (rst),
        .route  (route),
        .lvl    (pirq_lvl),
        .lvl_map(lvl_map)
    );

    pirq_pic_merge #(.N_PIRQ(N_PIRQ), .N_PIC(N_PIC)) u_merge (
        .lvl_map(lvl_map),
        .pic    (pic_out)
    );

    pirq_route_status #(.N_PIRQ(N_PIRQ), .N_PIC(N_PIC)) u_stat (
        .route(route),
        .en   (route_en),
        .irq  (route_irq)
    );

    assign dev_pirq    = slot_to_line(dev_fn[4:3], dev_pin);
    assign unused_bits = ^{dev_fn[7:5], dev_fn[2:0], wr_hit};
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
    parameter int N_PIRQ = 4,
    parameter int N_PIC  = 16,
    parameter int BASE   = 8'h60
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_rdata,
    input logic [N_PIRQ-1:0] pirq_lvl,
    input logic [N_PIC-1:0]  pic_out,
    input logic [N_PIRQ-1:0] route_en
);
    logic [7:0] off;
    logic       in_rng, wr_in;
    assign off    = cfg_addr - 8'(BASE);
    assign in_rng = off < 8'(N_PIRQ);
    assign wr_in  = cfg_we && in_rng;

    // R2: offsets outside the steering window read as zero
    a_r2_read_outside: assert property (@(posedge clk) disable iff (rst)
        !in_rng |-> cfg_rdata == 8'h00);

    // R3: steering state moves only after a write into the window
    a_r3_route_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_in) |-> $stable(route_en));

    // R5: with every line disabled in the prior cycle nothing is driven
    a_r5_all_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(|route_en) |-> pic_out == '0);

    // R6: each line drives at most one controller input
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        $countones(pic_out) <= $countones($past(pirq_lvl)));

    // R4: an active output needs an active line one cycle earlier
    a_r4_needs_level: assert property (@(posedge clk) disable iff (rst)
        (|pic_out) |-> (|$past(pirq_lvl)));
endmodule

bind pirq_router pirq_router_chk #(.N_PIRQ(N_PIRQ), .N_PIC(N_PIC), .BASE(BASE)) u_chk (.*);

// File: tb/pirq_router_bench.sv
module pirq_router_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [3:0]  pirq_lvl = 4'h0;
    logic [15:0] pic_out;
    logic [3:0]  route_en;
    logic [15:0] route_irq;
    logic [7:0]  dev_fn = 8'h00;
    logic [1:0]  dev_pin = 2'd0;
    logic [1:0]  dev_pirq;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] mdl [4];

    always #2 clk = ~clk;

    pirq_router u_pirq_router (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_pic(input logic [3:0] lv);
        logic [15:0] r = '0;
        for (int p = 0; p < 4; p++)
            if (lv[p] && mdl[p] < 8'd16) r[mdl[p][3:0]] = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] exp_irq();
        logic [15:0] r = '0;
        for (int p = 0; p < 4; p++)
            if (mdl[p] < 8'd16) r[p*4 +: 4] = mdl[p][3:0];
        return r;
    endfunction

    function automatic logic [3:0] exp_en();
        logic [3:0] r;
        for (int p = 0; p < 4; p++) r[p] = mdl[p] < 8'd16;
        return r;
    endfunction

    // Returns at the negedge after the sampling posedge: steering updated, map not yet.
    task automatic wr_cfg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a >= 8'h60 && a <= 8'h63) mdl[a - 8'h60] = d;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        chk(req, {8'h00, cfg_rdata}, {8'h00, exp});
    endtask

    task automatic lvl_chk(input string req, input logic [3:0] v);
        pirq_lvl = v;
        @(negedge clk);
        chk(req, pic_out, exp_pic(v));
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) rd_chk("R1 reset route", 8'h60 + 8'(i), 8'h80);
        chk("R1 reset pic_out", pic_out, 16'h0);
        chk("R1 reset route_en", {12'h0, route_en}, 16'h0);
    endtask

    task automatic t_readback;
        wr_cfg(8'h60, 8'h05);
        wr_cfg(8'h61, 8'h0A);
        wr_cfg(8'h62, 8'h10);
        wr_cfg(8'h63, 8'h8F);
        rd_chk("R2 read A", 8'h60, 8'h05);
        rd_chk("R2 read B", 8'h61, 8'h0A);
        rd_chk("R2 read C", 8'h62, 8'h10);
        rd_chk("R2 read D", 8'h63, 8'h8F);
        rd_chk("R2 read outside high", 8'h64, 8'h00);
        rd_chk("R2 read outside low", 8'h5F, 8'h00);
        chk("R8 route_en", {12'h0, route_en}, {12'h0, exp_en()});
        chk("R8 R5 route_irq", route_irq, exp_irq());
    endtask

    task automatic t_ignore;
        wr_cfg(8'h5F, 8'h03);
        wr_cfg(8'h64, 8'h03);
        wr_cfg(8'h00, 8'h03);
        for (int i = 0; i < 4; i++) rd_chk("R3 unchanged", 8'h60 + 8'(i), mdl[i]);
        chk("R3 route_irq unchanged", route_irq, exp_irq());
        @(negedge clk);
        chk("R3 pic_out unchanged", pic_out, 16'h0);
    endtask

    task automatic t_levels;
        lvl_chk("R4 line A to 5", 4'b0001);
        chk("R4 bit5", pic_out, 16'h0020);
        lvl_chk("R4 line B to 10", 4'b0010);
        lvl_chk("R5 line C 0x10 disabled", 4'b0100);
        lvl_chk("R5 line D 0x8F disabled", 4'b1000);
        chk("R5 quiet", pic_out, 16'h0);
        wr_cfg(8'h60, 8'h00);
        wr_cfg(8'h63, 8'h0F);
        lvl_chk("R4 edge inputs 0 and 15", 4'b1001);
        chk("R4 bits 0 and 15", pic_out, 16'h8001);
        chk("R8 route_irq D=15", route_irq, exp_irq());
        lvl_chk("R4 release", 4'b0000);
    endtask

    task automatic t_wired_or;
        wr_cfg(8'h60, 8'h03);
        wr_cfg(8'h61, 8'h03);
        wr_cfg(8'h62, 8'h03);
        wr_cfg(8'h63, 8'h07);
        lvl_chk("R6 A alone", 4'b0001);
        lvl_chk("R6 B and C", 4'b0110);
        chk("R6 shared bit3", pic_out, 16'h0008);
        lvl_chk("R6 all", 4'b1111);
        lvl_chk("R6 A released B held", 4'b0010);
        chk("R6 still bit3", pic_out, 16'h0008);
        lvl_chk("R6 D only", 4'b1000);
    endtask

    task automatic t_reroute;
        pirq_lvl = 4'b0001;
        @(negedge clk);
        chk("R7 before", pic_out, 16'h0008);
        wr_cfg(8'h60, 8'h09);
        chk("R7 old mapping after 1 edge", pic_out, 16'h0008);
        chk("R8 status follows write", route_irq[3:0], 4'd9);
        @(negedge clk);
        chk("R7 new mapping after 2 edges", pic_out, 16'h0200);
        wr_cfg(8'h60, 8'h80);
        @(negedge clk);
        chk("R7 R5 disabled by write", pic_out, 16'h0000);
        pirq_lvl = 4'b0000;
        @(negedge clk);
    endtask

    task automatic t_helper;
        for (int s = 0; s < 32; s++)
            for (int p = 0; p < 4; p++) begin
                dev_fn = {s[4:0], 3'(s)};
                dev_pin = 2'(p);
                #1;
                chk("R9 slot rotation", {14'h0, dev_pirq}, 16'((p + s + 3) % 4));
            end
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = 8'h80;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_ignore();
        t_levels();
        t_wired_or();
        t_reroute();
        t_helper();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule